// File: doc/BRIEF.md
# Privileged Status and Exception-Return Unit

This block holds the privileged machine state of a MIPS-style system coprocessor: the processor status word, the configuration word, the two saved return addresses (normal and error), a free-running cycle count, and a small bank of plain scratch registers. A pipeline presents one operation per clock on `op_code`. The operation is a move into a numbered register, a move out of one, an exception return, an interrupt enable, an interrupt disable, or one of four coprocessor-condition branches. The block answers one cycle later on registered outputs.

A move out returns the 32-bit value sign-extended to 64 bits. An exception return or a taken branch raises `redirect` for one cycle and gives the new fetch address. The branch condition is built from two 10-bit vectors that come from the DMA controller: a completion-status vector and a watch mask. The effective privilege mode and the global interrupt-enable bit are driven out continuously.

Operation codes are: 0 idle, 1 move-to, 2 move-from, 3 exception return, 4 interrupt enable, 5 interrupt disable, and 8 to 11 for the branches. Every other code is a no-op. The register numbers used are 9 for the count, 12 for status, 14 for the saved return address, 16 for config and 30 for the error return address. All other numbers up to 31 are plain storage.

Top module: `priv_status_unit`

## Requirements
- R1: A synchronous active-high reset clears status, the count, both return addresses, the scratch registers and all outputs. Config resets to 0x440.
- R2: Code 1 writes `wr_data` to register `reg_sel`. Code 2 raises `rd_valid` on the next cycle, with the register value sign-extended from bit 31 into 64-bit `rd_data`.
- R3: Status fields are: exception level at bit 1, error level at bit 2, mode at bits 4:3, interrupt-enable at bit 16 and enable-override at bit 17. A status read returns the stored word ANDed with 0xF0C79C1F.
- R4: A config write keeps bits 11:6 at the fixed pattern 010001 (0x440) whatever value is written. The other bits take the written value.
- R5: The count adds one on every clock edge out of reset. A write loads the written value in place of that edge's increment. A read returns the value held before its own edge.
- R6: Code 3 with the error-level bit set redirects to the error return address and clears only the error-level bit.
- R7: Code 3 with the error-level bit clear redirects to the saved return address and clears the exception-level bit.
- R8: Codes 4 and 5 set and clear the interrupt-enable bit. They do this only when the enable-override, exception-level or error-level bit is set, or the mode field is 0. Otherwise they have no effect on `irq_en`.
- R9: The condition is true exactly when every bit of (`dma_stat_in` OR NOT `dma_mask_in`) is 1. Bit 0 of a branch code chooses the sense: 1 branches on true, 0 on false. A taken branch redirects to `wr_data`.
- R10: Bit 1 of a branch code marks a likely form. When a likely form is not taken, the block redirects to `pc_in` + 4. When a plain form is not taken, there is no redirect.
- R11: `priv_mode` is 0 while exception level or error level is set, and the mode field otherwise. It follows a status change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation for this cycle |
| reg_sel | input | 5 | Register number for moves |
| wr_data | input | 32 | Move-to data, or branch target |
| pc_in | input | 32 | Address of the delay slot of a branch |
| dma_stat_in | input | 10 | DMA completion-status vector |
| dma_mask_in | input | 10 | DMA watch mask |
| rd_valid | output | 1 | Move-from result valid |
| rd_data | output | 64 | Sign-extended move-from result |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Redirect address |
| priv_mode | output | 2 | Effective privilege mode |
| irq_en | output | 1 | Global interrupt-enable bit |

## Verification
The count's per-cycle increment and a software access to the count can land on the same edge. A write to register 9 must replace the increment, and a read must return the value from before that edge. The bench makes both collide by writing the count and reading it back after a known number of idle cycles. It also mixes count reads and writes at random into the stream of operations. The expected value is a bench model that advances one per stepped cycle. The checker also asserts the +1 step on every edge without a write, and the exact load on an edge with a write.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [3:0] {
    OP_IDLE      = 4'd0,
    OP_MOVE_TO   = 4'd1,
    OP_MOVE_FROM = 4'd2,
    OP_RETURN    = 4'd3,
    OP_IEN_SET   = 4'd4,
    OP_IEN_CLR   = 4'd5,
    OP_BR_F      = 4'd8,
    OP_BR_T      = 4'd9,
    OP_BR_FL     = 4'd10,
    OP_BR_TL     = 4'd11
  } op_e;

  localparam int BIT_EXL = 1;
  localparam int BIT_ERL = 2;
  localparam int KSU_LO  = 3;
  localparam int KSU_HI  = 4;
  localparam int BIT_EIE = 16;
  localparam int BIT_EDI = 17;

  localparam logic [31:0] STATUS_RD_MASK = 32'hF0C7_9C1F;
  localparam logic [31:0] CFG_FIXED_MASK = 32'h0000_0FC0;
  localparam logic [31:0] CFG_FIXED_VAL  = 32'h0000_0440;
endpackage

// File: rtl/psu_count.sv
module psu_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load) count_q <= load_val;
    else           count_q <= count_q + W'(1);
  end
endmodule

// File: rtl/psu_brcond.sv
module psu_brcond #(
  parameter int DMA_W = 10
) (
  input  logic [DMA_W-1:0] stat_in,
  input  logic [DMA_W-1:0] mask_in,
  output logic             cond
);
  logic [DMA_W-1:0] lane;

  for (genvar i = 0; i < DMA_W; i++) begin : g_lane
    assign lane[i] = stat_in[i] | ~mask_in[i];
  end

  assign cond = &lane;
endmodule

// File: rtl/psu_state.sv
module psu_state
  import psu_pkg::*;
#(
  parameter int W          = 32,
  parameter int SEL_W      = 5,
  parameter int STATUS_IDX = 12,
  parameter int CONFIG_IDX = 16,
  parameter int EPC_IDX    = 14,
  parameter int ERREPC_IDX = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             do_ret,
  input  logic             do_ien_set,
  input  logic             do_ien_clr,
  output logic [W-1:0]     status_q,
  output logic [W-1:0]     cfg_q,
  output logic [W-1:0]     epc_q,
  output logic [W-1:0]     errepc_q,
  output logic [1:0]       mode_q
);
  logic [W-1:0] status_d;
  logic         priv_ok;
  logic [1:0]   mode_d;

  assign priv_ok = status_q[BIT_EDI] | status_q[BIT_EXL] | status_q[BIT_ERL] |
                   (status_q[KSU_HI:KSU_LO] == 2'b00);

  always_comb begin
    status_d = status_q;
    if (wr_en && wr_sel == SEL_W'(STATUS_IDX)) status_d = wr_data;
    if (do_ret) begin
      if (status_q[BIT_ERL]) status_d[BIT_ERL] = 1'b0;
      else                   status_d[BIT_EXL] = 1'b0;
    end
    if (do_ien_set && priv_ok) status_d[BIT_EIE] = 1'b1;
    if (do_ien_clr && priv_ok) status_d[BIT_EIE] = 1'b0;
  end

  assign mode_d = (status_d[BIT_EXL] | status_d[BIT_ERL]) ? 2'b00
                                                          : status_d[KSU_HI:KSU_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      cfg_q    <= W'(CFG_FIXED_VAL);
      epc_q    <= '0;
      errepc_q <= '0;
      mode_q   <= 2'b00;
    end else begin
      status_q <= status_d;
      mode_q   <= mode_d;
      if (wr_en && wr_sel == SEL_W'(CONFIG_IDX))
        cfg_q <= (wr_data & ~W'(CFG_FIXED_MASK)) | W'(CFG_FIXED_VAL);
      if (wr_en && wr_sel == SEL_W'(EPC_IDX))    epc_q    <= wr_data;
      if (wr_en && wr_sel == SEL_W'(ERREPC_IDX)) errepc_q <= wr_data;
    end
  end
endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
  import psu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NREG       = 32,
  parameter int DMA_W      = 10,
  parameter int COUNT_IDX  = 9,
  parameter int STATUS_IDX = 12,
  parameter int EPC_IDX    = 14,
  parameter int CONFIG_IDX = 16,
  parameter int ERREPC_IDX = 30,
  localparam int SEL_W     = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          op_code,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W-1:0]   pc_in,
  input  logic [DMA_W-1:0]    dma_stat_in,
  input  logic [DMA_W-1:0]    dma_mask_in,
  output logic                rd_valid,
  output logic [2*DATA_W-1:0] rd_data,
  output logic                redirect,
  output logic [DATA_W-1:0]   redirect_pc,
  output logic [1:0]          priv_mode,
  output logic                irq_en
);
  logic                is_wr, is_rd, is_ret, is_br, br_sense, br_likely, cond;
  logic [DATA_W-1:0]   status_q, cfg_q, epc_q, errepc_q, count_q, rd_word;
  logic [DATA_W-1:0]   gen_q [NREG];

  assign is_wr     = (op_code == OP_MOVE_TO);
  assign is_rd     = (op_code == OP_MOVE_FROM);
  assign is_ret    = (op_code == OP_RETURN);
  assign is_br     = (op_code[3:2] == 2'b10);
  assign br_sense  = op_code[0];
  assign br_likely = op_code[1];

  psu_count #(.W(DATA_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (is_wr && reg_sel == SEL_W'(COUNT_IDX)),
    .load_val (wr_data),
    .count_q  (count_q)
  );

  psu_state #(
    .W(DATA_W), .SEL_W(SEL_W), .STATUS_IDX(STATUS_IDX),
    .CONFIG_IDX(CONFIG_IDX), .EPC_IDX(EPC_IDX), .ERREPC_IDX(ERREPC_IDX)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (is_wr),
    .wr_sel     (reg_sel),
    .wr_data    (wr_data),
    .do_ret     (is_ret),
    .do_ien_set (op_code == OP_IEN_SET),
    .do_ien_clr (op_code == OP_IEN_CLR),
    .status_q   (status_q),
    .cfg_q      (cfg_q),
    .epc_q      (epc_q),
    .errepc_q   (errepc_q),
    .mode_q     (priv_mode)
  );

  psu_brcond #(.DMA_W(DMA_W)) u_brcond (
    .stat_in (dma_stat_in),
    .mask_in (dma_mask_in),
    .cond    (cond)
  );

  // plain scratch registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) gen_q[i] <= '0;
    end else if (is_wr) begin
      gen_q[reg_sel] <= wr_data;
    end
  end

  always_comb begin
    if      (reg_sel == SEL_W'(STATUS_IDX)) rd_word = status_q & DATA_W'(STATUS_RD_MASK);
    else if (reg_sel == SEL_W'(CONFIG_IDX)) rd_word = cfg_q;
    else if (reg_sel == SEL_W'(COUNT_IDX))  rd_word = count_q;
    else if (reg_sel == SEL_W'(EPC_IDX))    rd_word = epc_q;
    else if (reg_sel == SEL_W'(ERREPC_IDX)) rd_word = errepc_q;
    else                                    rd_word = gen_q[reg_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) rd_data <= {{DATA_W{rd_word[DATA_W-1]}}, rd_word};
      redirect <= 1'b0;
      if (is_ret) begin
        redirect    <= 1'b1;
        redirect_pc <= status_q[BIT_ERL] ? errepc_q : epc_q;
      end else if (is_br) begin
        if (cond == br_sense) begin
          redirect    <= 1'b1;
          redirect_pc <= wr_data;
        end else if (br_likely) begin
          redirect    <= 1'b1;
          redirect_pc <= pc_in + DATA_W'(4);
        end
      end
    end
  end

  assign irq_en = status_q[BIT_EIE];
endmodule

// File: rtl/psu_checker.sv
module psu_checker
  import psu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 5,
  parameter int COUNT_IDX = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_code,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] count_q,
  input logic              rd_valid,
  input logic              redirect,
  input logic [1:0]        priv_mode,
  input logic              irq_en
);
  logic cnt_wr, priv_ok;
  assign cnt_wr  = (op_code == OP_MOVE_TO) && (reg_sel == SEL_W'(COUNT_IDX));
  assign priv_ok = status_q[BIT_EDI] | status_q[BIT_EXL] | status_q[BIT_ERL] |
                   (status_q[KSU_HI:KSU_LO] == 2'b00);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> count_q == $past(count_q) + DATA_W'(1)); // R5
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> count_q == $past(wr_data)); // R5
  AST_CFG_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    cfg_q[11:6] == 6'b010001); // R4
  AST_RET_ERROR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_RETURN && status_q[BIT_ERL]) |=> (!status_q[BIT_ERL] && redirect)); // R6
  AST_RET_EXC_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_RETURN && !status_q[BIT_ERL]) |=> (!status_q[BIT_EXL] && redirect)); // R7
  AST_IEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ((op_code == OP_IEN_SET || op_code == OP_IEN_CLR) && !priv_ok) |=> $stable(irq_en)); // R8
  AST_MODE_KERNEL: assert property (@(posedge clk) disable iff (rst)
    (status_q[BIT_EXL] || status_q[BIT_ERL]) |-> priv_mode == 2'b00); // R11
  AST_RD_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(op_code) == OP_MOVE_FROM); // R2
  AST_REDIRECT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    redirect |-> ($past(op_code) == OP_RETURN || $past(op_code[3:2]) == 2'b10)); // R9
endmodule

bind priv_status_unit psu_checker #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .COUNT_IDX(COUNT_IDX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_code   (op_code),
  .reg_sel   (reg_sel),
  .wr_data   (wr_data),
  .status_q  (status_q),
  .cfg_q     (cfg_q),
  .count_q   (count_q),
  .rd_valid  (rd_valid),
  .redirect  (redirect),
  .priv_mode (priv_mode),
  .irq_en    (irq_en)
);

// File: tb/priv_status_unit_tb.sv
module priv_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic [4:0]  reg_sel = '0;
  logic [31:0] wr_data = '0, pc_in = '0;
  logic [9:0]  dma_stat_in = '0, dma_mask_in = '0;
  logic        rd_valid, redirect, irq_en;
  logic [63:0] rd_data;
  logic [31:0] redirect_pc;
  logic [1:0]  priv_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_status, m_cfg, m_epc, m_err, m_cnt;
  logic [31:0] m_mem [32];

  always #4 clk = ~clk;

  priv_status_unit u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .reg_sel(reg_sel), .wr_data(wr_data),
    .pc_in(pc_in), .dma_stat_in(dma_stat_in), .dma_mask_in(dma_mask_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .redirect(redirect),
    .redirect_pc(redirect_pc), .priv_mode(priv_mode), .irq_en(irq_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(input logic [31:0] s);
    return (s[1] | s[2]) ? 2'b00 : s[4:3];
  endfunction

  function automatic logic ien_ok(input logic [31:0] s);
    return s[17] | s[2] | s[1] | (s[4:3] == 2'b00);
  endfunction

  function automatic logic [31:0] read_model(input logic [4:0] sel);
    case (sel)
      5'd12:   return m_status & 32'hF0C79C1F;
      5'd16:   return m_cfg;
      5'd9:    return m_cnt;
      5'd14:   return m_epc;
      5'd30:   return m_err;
      default: return m_mem[sel];
    endcase
  endfunction

  task automatic step(input logic [3:0] op, input logic [4:0] sel, input logic [31:0] d,
                      input logic [31:0] pc, input logic [9:0] st, input logic [9:0] mk);
    logic        exp_redir, cond;
    logic [31:0] exp_pc, rw;
    string       rtag, dtag;
    exp_redir = 1'b0; exp_pc = '0; rtag = "R9";
    rw = read_model(sel);
    cond = &(st | ~mk);
    op_code = op; reg_sel = sel; wr_data = d; pc_in = pc;
    dma_stat_in = st; dma_mask_in = mk;
    @(posedge clk);
    if (op == 4'd1) begin
      case (sel)
        5'd12:   m_status = d;
        5'd16:   m_cfg = (d & ~32'h0FC0) | 32'h0440;
        5'd14:   m_epc = d;
        5'd30:   m_err = d;
        5'd9:    ;
        default: m_mem[sel] = d;
      endcase
    end
    m_cnt = (op == 4'd1 && sel == 5'd9) ? d : m_cnt + 32'd1;
    if (op == 4'd3) begin
      exp_redir = 1'b1;
      if (m_status[2]) begin exp_pc = m_err; m_status[2] = 1'b0; rtag = "R6"; end
      else             begin exp_pc = m_epc; m_status[1] = 1'b0; rtag = "R7"; end
    end
    if ((op == 4'd4 || op == 4'd5) && ien_ok(m_status)) m_status[16] = (op == 4'd4);
    if (op[3:2] == 2'b10) begin
      if (cond == op[0])  begin exp_redir = 1'b1; exp_pc = d; end
      else if (op[1])     begin exp_redir = 1'b1; exp_pc = pc + 32'd4; rtag = "R10"; end
      else rtag = "R10";
    end
    @(negedge clk);
    op_code = '0;
    chk("R2 rd_valid", rd_valid, op == 4'd2);
    if (op == 4'd2) begin
      case (sel)
        5'd12: dtag = "R3 status read";
        5'd16: dtag = "R4 config read";
        5'd9:  dtag = "R5 count read";
        default: dtag = "R2 read data";
      endcase
      chk(dtag, rd_data, {{32{rw[31]}}, rw});
    end
    chk({rtag, " redirect"}, redirect, exp_redir);
    if (exp_redir) chk({rtag, " redirect_pc"}, redirect_pc, exp_pc);
    chk("R8 irq_en", irq_en, m_status[16]);
    chk("R11 priv_mode", priv_mode, mode_of(m_status));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'd0, 5'd0, 32'd0, 32'd0, 10'd0, 10'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-reqs act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  ops [10];
    logic [4:0]  sels [5];
    ops  = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd11};
    sels = '{5'd9, 5'd12, 5'd14, 5'd16, 5'd30};
    m_status = '0; m_cfg = 32'h440; m_epc = '0; m_err = '0; m_cnt = '0;
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    chk("R1 rd_valid", rd_valid, 1'b0);
    chk("R1 redirect", redirect, 1'b0);
    chk("R1 irq_en", irq_en, 1'b0);
    chk("R1 priv_mode", priv_mode, 2'b00);
    step(4'd2, 5'd9, 0, 0, 0, 0);   // R1 count starts at zero
    step(4'd2, 5'd16, 0, 0, 0, 0);  // R1 config 0x440
    step(4'd2, 5'd12, 0, 0, 0, 0);
    step(4'd2, 5'd5, 0, 0, 0, 0);
    // R3 mask and sign extension
    step(4'd1, 5'd12, 32'hFFFF_FFFF, 0, 0, 0);
    step(4'd2, 5'd12, 0, 0, 0, 0);
    // R4 fixed config bits
    step(4'd1, 5'd16, 32'h0, 0, 0, 0);
    step(4'd2, 5'd16, 0, 0, 0, 0);
    step(4'd1, 5'd16, 32'hFFFF_FFFF, 0, 0, 0);
    step(4'd2, 5'd16, 0, 0, 0, 0);
    // R5 count write collides with increment, read after known gap
    step(4'd1, 5'd9, 32'd100, 0, 0, 0);
    idle(5);
    step(4'd2, 5'd9, 0, 0, 0, 0);
    step(4'd1, 5'd9, 32'hFFFF_FFFF, 0, 0, 0);
    step(4'd2, 5'd9, 0, 0, 0, 0);
    // R6/R7 exception return ordering
    step(4'd1, 5'd14, 32'h0000_1000, 0, 0, 0);
    step(4'd1, 5'd30, 32'h0000_2000, 0, 0, 0);
    step(4'd1, 5'd12, 32'h0000_0016, 0, 0, 0);
    step(4'd3, 0, 0, 0, 0, 0);
    step(4'd3, 0, 0, 0, 0, 0);
    // R8 enable gating
    step(4'd1, 5'd12, 32'h0000_0010, 0, 0, 0);
    step(4'd4, 0, 0, 0, 0, 0);
    step(4'd1, 5'd12, 32'h0001_0010, 0, 0, 0);
    step(4'd5, 0, 0, 0, 0, 0);
    step(4'd1, 5'd12, 32'h0002_0010, 0, 0, 0);
    step(4'd5, 0, 0, 0, 0, 0);
    step(4'd4, 0, 0, 0, 0, 0);
    step(4'd1, 5'd12, 32'h0000_0000, 0, 0, 0);
    step(4'd4, 0, 0, 0, 0, 0);
    // R9/R10 condition boundaries
    for (int b = 8; b < 12; b++) begin
      step(4'(b), 0, 32'hA000_0000, 32'h0000_4000, 10'h000, 10'h000);
      step(4'(b), 0, 32'hA000_0010, 32'h0000_4010, 10'h3FF, 10'h3FF);
      step(4'(b), 0, 32'hA000_0020, 32'h0000_4020, 10'h3FE, 10'h3FF);
      step(4'(b), 0, 32'hA000_0030, 32'h0000_4030, 10'h000, 10'h200);
    end
    // constrained random mix
    r = $urandom(32'd20240611);
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] s;
      logic [9:0] mk, st;
      r = $urandom();
      s = (r[2:0] < 3'd5) ? sels[r[2:0]] : 5'($urandom());
      mk = 10'($urandom());
      st = r[3] ? 10'h3FF : (r[4] ? (mk | 10'($urandom() & 32'h1)) : 10'($urandom()));
      step(ops[$urandom() % 10], s, $urandom(), $urandom(), st, mk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule